// File: doc/BRIEF.md
# Sv39 Page Table Walker

The walker turns a 39-bit virtual address into a 56-bit physical address. It reads 8-byte page table entries through a memory read port that allows one read in flight. A start pulse carries the virtual address, the root table base and an access-type tag. The walk begins at level 2. At each level the walker forms the entry address, issues one read and classifies the returned entry. The walk ends on an invalid entry, on a leaf, or on a fault.

Permission rules are not evaluated inside the block. An external checker looks at the returned entry and the latched access tag, and returns one pass/fail bit with the read response. A leaf found above level 0 is a superpage. It must have its low physical-page bits clear. Its output page number takes the low virtual-page bits.

When the walk finishes, a one-cycle `done_o` pulse marks the moment. The result registers hold their values until the next walk finishes.

Top module: `sv39_walker`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `done_o` and `mem_req_o` are 0.
- R2: The first read of a walk addresses `root_base_i + 8*vaddr[38:30]`. `busy_o` and `mem_req_o` rise in the same cycle.
- R3: `mem_req_o` is a one-cycle pulse. No new request is issued until the response to the previous one arrives, and none is issued while idle.
- R4: An entry with bit 0 (valid) clear, or with bit 2 (write) set and bit 1 (read) clear, ends the walk with fault code 1.
- R5: An entry with bit 0 set and bits 1, 2 and 3 clear is a pointer. At level 0 a pointer ends the walk with fault code 1. At a higher level the next read addresses `{pte[53:10],12'h000} + 8*vaddr[12+9*L' +: 9]`, where L' is the level minus one.
- R6: A leaf (valid, not invalid, not a pointer) with `perm_ok_i` low at the response ends the walk with fault code 2.
- R7: A permitted leaf at level L>0 whose `pte[53:10]` has any of its low 9*L bits set ends the walk with fault code 3, and `level_o` reports L.
- R8: A permitted, aligned leaf ends with `ok_o`=1 and fault code 0. Here `paddr_o = {ppn | (vaddr[38:12] & mask), vaddr[11:0]}`, with mask = (1<<9L)-1 and ppn = `pte[53:10]`.
- R9: `global_o` is the OR of bit 5 over every entry read in the walk.
- R10: An error flagged with a read response ends the walk with fault code 4.
- R11: On every ending other than code 4, `pte_o`, `pte_addr_o` and `level_o` give the last entry, its address and its level.
- R12: `busy_o` stays high from the cycle after start until the cycle `done_o` is high. A start while busy is ignored.
- R13: `done_o` is high for exactly one cycle per walk, one cycle after the last response. The results then hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a walk (taken only when idle) |
| vaddr_i | input | 39 | Virtual address to translate |
| root_base_i | input | 56 | Physical base of the root table |
| acc_i | input | 2 | Access-type tag, latched for the permission checker |
| perm_ok_i | input | 1 | Permission verdict, sampled with the read response |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 64 | Read response entry |
| mem_rerr_i | input | 1 | Read response carries an access error |
| mem_req_o | output | 1 | Read request pulse |
| mem_addr_o | output | 56 | Read address |
| access_o | output | 2 | Latched access-type tag |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Walk finished (one cycle) |
| ok_o | output | 1 | Last walk succeeded |
| fault_o | output | 3 | Fault code: 0 none, 1 invalid, 2 no permission, 3 misaligned, 4 access |
| paddr_o | output | 56 | Translated physical address |
| pte_o | output | 64 | Last entry read |
| pte_addr_o | output | 56 | Address of the last entry |
| level_o | output | 2 | Level of the last entry |
| global_o | output | 1 | Accumulated global flag |

## Verification
The hardest cases to reach are the three-read walk whose last entry is still a pointer, and a misaligned superpage at level 1. Neither appears unless the table contents are shaped for it. The bench acts as the memory itself and picks each entry from the level it is asked for. It mixes directed tables for these endings with random kinds per level, random alignment and random response latency. It also pulses start during a walk to show that the pulse is dropped.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  // entry flag positions decoded by the walker
  localparam int unsigned PTE_V_BIT   = 0;
  localparam int unsigned PTE_R_BIT   = 1;
  localparam int unsigned PTE_W_BIT   = 2;
  localparam int unsigned PTE_X_BIT   = 3;
  localparam int unsigned PTE_G_BIT   = 5;
  localparam int unsigned PTE_PPN_LSB = 10;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_INVALID  = 3'd1,
    FLT_NOPERM   = 3'd2,
    FLT_MISALIGN = 3'd3,
    FLT_ACCESS   = 3'd4
  } ptw_fault_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } ptw_state_e;

  typedef enum logic [1:0] {
    KIND_BAD  = 2'd0,
    KIND_PTR  = 2'd1,
    KIND_LEAF = 2'd2
  } pte_kind_e;

endpackage

// File: rtl/ptw_rst_sync.sv
module ptw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned PA_W    = 56,
  parameter int unsigned IDX_W   = 9,
  parameter int unsigned LEVELS  = 3,
  parameter int unsigned ENT_LOG = 3,
  localparam int unsigned VPN_W  = IDX_W * LEVELS,
  localparam int unsigned LVL_W  = $clog2(LEVELS)
) (
  input  logic [PA_W-1:0]  base_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [LVL_W-1:0] level_i,
  output logic [PA_W-1:0]  addr_o
);

  logic [IDX_W-1:0] slice [LEVELS];
  logic [IDX_W-1:0] idx;

  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    assign slice[g] = vpn_i[g*IDX_W +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (level_i == LVL_W'(k)) begin
        idx = slice[k];
      end
    end
  end

  assign addr_o = base_i + (PA_W'(idx) << ENT_LOG);

endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
  import ptw_pkg::*;
(
  input  logic      v_i,
  input  logic      r_i,
  input  logic      w_i,
  input  logic      x_i,
  output pte_kind_e kind_o
);

  logic bad;
  logic ptr;

  assign bad = !v_i || (w_i && !r_i);
  assign ptr = !bad && !r_i && !x_i;

  always_comb begin
    if (bad) begin
      kind_o = KIND_BAD;
    end else if (ptr) begin
      kind_o = KIND_PTR;
    end else begin
      kind_o = KIND_LEAF;
    end
  end

endmodule

// File: rtl/ptw_leaf_merge.sv
module ptw_leaf_merge #(
  parameter int unsigned PPN_W  = 44,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned LEVELS = 3,
  localparam int unsigned VPN_W = IDX_W * LEVELS,
  localparam int unsigned LVL_W = $clog2(LEVELS)
) (
  input  logic [PPN_W-1:0] ppn_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             misalign_o,
  output logic [PPN_W-1:0] ppn_o
);

  logic [PPN_W-1:0] mask;
  logic [PPN_W-1:0] vpn_ext;

  // one group of IDX_W mask bits per level below the current one
  for (genvar g = 0; g < LEVELS; g++) begin : g_mask
    assign mask[g*IDX_W +: IDX_W] = (32'(level_i) > g) ? {IDX_W{1'b1}} : '0;
  end

  if (PPN_W > VPN_W) begin : g_mask_hi
    assign mask[PPN_W-1:VPN_W] = '0;
  end

  assign vpn_ext    = PPN_W'(vpn_i);
  assign misalign_o = |(ppn_i & mask);
  assign ppn_o      = ppn_i | (vpn_ext & mask);

endmodule

// File: rtl/sv39_walker.sv
module sv39_walker
  import ptw_pkg::*;
#(
  parameter int unsigned VA_W    = 39,
  parameter int unsigned PA_W    = 56,
  parameter int unsigned PG_BITS = 12,
  parameter int unsigned IDX_W   = 9,
  parameter int unsigned LEVELS  = 3,
  parameter int unsigned PTE_W   = 64,
  parameter int unsigned ACC_W   = 2,
  localparam int unsigned VPN_W  = VA_W - PG_BITS,
  localparam int unsigned PPN_W  = PA_W - PG_BITS,
  localparam int unsigned LVL_W  = $clog2(LEVELS),
  localparam int unsigned ENT_LOG = $clog2(PTE_W / 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [PA_W-1:0]  root_base_i,
  input  logic [ACC_W-1:0] acc_i,
  input  logic             perm_ok_i,
  input  logic             mem_rvalid_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  input  logic             mem_rerr_i,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic [ACC_W-1:0] access_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ok_o,
  output logic [2:0]       fault_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic [PTE_W-1:0] pte_o,
  output logic [PA_W-1:0]  pte_addr_o,
  output logic [LVL_W-1:0] level_o,
  output logic             global_o
);

  logic rst_n_s;

  ptw_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  // walk context
  ptw_state_e       state_q, state_d;
  logic [VA_W-1:0]  vaddr_q, vaddr_d;
  logic [PA_W-1:0]  base_q, base_d;
  logic [LVL_W-1:0] level_q, level_d;
  logic             glob_q, glob_d;
  logic [ACC_W-1:0] acc_q, acc_d;

  // results
  logic             done_q, done_d;
  logic             ok_q, ok_d;
  ptw_fault_e       fault_q, fault_d;
  logic [PA_W-1:0]  paddr_q, paddr_d;
  logic [PTE_W-1:0] pte_q, pte_d;
  logic [PA_W-1:0]  pte_addr_q, pte_addr_d;
  logic [LVL_W-1:0] lvl_out_q, lvl_out_d;
  logic             glob_out_q, glob_out_d;

  logic             ctx_en;
  logic             res_en;

  logic [PA_W-1:0]  entry_addr;
  pte_kind_e        kind;
  logic [PPN_W-1:0] pte_ppn;
  logic [PPN_W-1:0] leaf_ppn;
  logic             misalign;
  logic             pte_glob;
  logic             resp_take;

  assign pte_ppn   = mem_rdata_i[PTE_PPN_LSB +: PPN_W];
  assign pte_glob  = mem_rdata_i[PTE_G_BIT];
  assign resp_take = (state_q == ST_WAIT) && mem_rvalid_i;

  ptw_addr_gen #(
    .PA_W    (PA_W),
    .IDX_W   (IDX_W),
    .LEVELS  (LEVELS),
    .ENT_LOG (ENT_LOG)
  ) u_addr_gen (
    .base_i  (base_q),
    .vpn_i   (vaddr_q[PG_BITS +: VPN_W]),
    .level_i (level_q),
    .addr_o  (entry_addr)
  );

  ptw_pte_decode u_decode (
    .v_i    (mem_rdata_i[PTE_V_BIT]),
    .r_i    (mem_rdata_i[PTE_R_BIT]),
    .w_i    (mem_rdata_i[PTE_W_BIT]),
    .x_i    (mem_rdata_i[PTE_X_BIT]),
    .kind_o (kind)
  );

  ptw_leaf_merge #(
    .PPN_W  (PPN_W),
    .IDX_W  (IDX_W),
    .LEVELS (LEVELS)
  ) u_merge (
    .ppn_i      (pte_ppn),
    .vpn_i      (vaddr_q[PG_BITS +: VPN_W]),
    .level_i    (level_q),
    .misalign_o (misalign),
    .ppn_o      (leaf_ppn)
  );

  // next-state logic
  always_comb begin
    state_d    = state_q;
    vaddr_d    = vaddr_q;
    base_d     = base_q;
    level_d    = level_q;
    glob_d     = glob_q;
    acc_d      = acc_q;
    done_d     = 1'b0;
    ok_d       = ok_q;
    fault_d    = fault_q;
    paddr_d    = paddr_q;
    pte_d      = pte_q;
    pte_addr_d = pte_addr_q;
    lvl_out_d  = lvl_out_q;
    glob_out_d = glob_out_q;

    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          vaddr_d = vaddr_i;
          base_d  = root_base_i;
          level_d = LVL_W'(LEVELS - 1);
          glob_d  = 1'b0;
          acc_d   = acc_i;
          state_d = ST_REQ;
        end
      end

      ST_REQ: begin
        state_d = ST_WAIT;
      end

      ST_WAIT: begin
        if (mem_rvalid_i) begin
          if (mem_rerr_i) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            ok_d    = 1'b0;
            fault_d = FLT_ACCESS;
          end else begin
            glob_d     = glob_q | pte_glob;
            pte_d      = mem_rdata_i;
            pte_addr_d = entry_addr;
            lvl_out_d  = level_q;
            glob_out_d = glob_q | pte_glob;
            unique case (kind)
              KIND_PTR: begin
                if (level_q == '0) begin
                  state_d = ST_IDLE;
                  done_d  = 1'b1;
                  ok_d    = 1'b0;
                  fault_d = FLT_INVALID;
                end else begin
                  base_d  = {pte_ppn, {PG_BITS{1'b0}}};
                  level_d = level_q - 1'b1;
                  state_d = ST_REQ;
                end
              end
              KIND_LEAF: begin
                state_d = ST_IDLE;
                done_d  = 1'b1;
                if (!perm_ok_i) begin
                  ok_d    = 1'b0;
                  fault_d = FLT_NOPERM;
                end else if (misalign) begin
                  ok_d    = 1'b0;
                  fault_d = FLT_MISALIGN;
                end else begin
                  ok_d    = 1'b1;
                  fault_d = FLT_NONE;
                  paddr_d = {leaf_ppn, vaddr_q[PG_BITS-1:0]};
                end
              end
              default: begin
                state_d = ST_IDLE;
                done_d  = 1'b1;
                ok_d    = 1'b0;
                fault_d = FLT_INVALID;
              end
            endcase
          end
        end
      end

      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  assign ctx_en = ((state_q == ST_IDLE) && start_i) || resp_take;
  assign res_en = resp_take;

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      vaddr_q <= '0;
      base_q  <= '0;
      level_q <= '0;
      glob_q  <= 1'b0;
      acc_q   <= '0;
    end else if (ctx_en) begin
      vaddr_q <= vaddr_d;
      base_q  <= base_d;
      level_q <= level_d;
      glob_q  <= glob_d;
      acc_q   <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ok_q       <= 1'b0;
      fault_q    <= FLT_NONE;
      paddr_q    <= '0;
      pte_q      <= '0;
      pte_addr_q <= '0;
      lvl_out_q  <= '0;
      glob_out_q <= 1'b0;
    end else if (res_en) begin
      ok_q       <= ok_d;
      fault_q    <= fault_d;
      paddr_q    <= paddr_d;
      pte_q      <= pte_d;
      pte_addr_q <= pte_addr_d;
      lvl_out_q  <= lvl_out_d;
      glob_out_q <= glob_out_d;
    end
  end

  assign mem_req_o  = (state_q == ST_REQ);
  assign mem_addr_o = entry_addr;
  assign access_o   = acc_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign ok_o       = ok_q;
  assign fault_o    = fault_q;
  assign paddr_o    = paddr_q;
  assign pte_o      = pte_q;
  assign pte_addr_o = pte_addr_q;
  assign level_o    = lvl_out_q;
  assign global_o   = glob_out_q;

endmodule

// File: rtl/sv39_walker_chk.sv
module sv39_walker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_req_o,
  input logic       mem_rvalid_i,
  input logic       mem_rerr_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       ok_o,
  input logic [2:0] fault_o,
  input logic [1:0] level_o
);

  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |=> !mem_req_o);

  // R3
  no_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o);

  // R2
  first_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> mem_req_o);

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R10
  acc_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !mem_req_o && mem_rvalid_i && mem_rerr_i) |=> (done_o && fault_o == 3'd4));

  // R8
  ok_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ok_o == (fault_o == 3'd0)));

  // R7
  misalign_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fault_o == 3'd3) |-> (level_o != 2'd0));

endmodule

bind sv39_walker sv39_walker_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_req_o    (mem_req_o),
  .mem_rvalid_i (mem_rvalid_i),
  .mem_rerr_i   (mem_rerr_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .ok_o         (ok_o),
  .fault_o      (fault_o),
  .level_o      (level_o)
);

// File: tb/tb_sv39_walker.sv
module tb_sv39_walker;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [38:0] vaddr_i;
  logic [55:0] root_base_i;
  logic [1:0]  acc_i;
  logic        perm_ok_i;
  logic        mem_rvalid_i;
  logic [63:0] mem_rdata_i;
  logic        mem_rerr_i;
  logic        mem_req_o;
  logic [55:0] mem_addr_o;
  logic [1:0]  access_o;
  logic        busy_o;
  logic        done_o;
  logic        ok_o;
  logic [2:0]  fault_o;
  logic [55:0] paddr_o;
  logic [63:0] pte_o;
  logic [55:0] pte_addr_o;
  logic [1:0]  level_o;
  logic        global_o;

  int checks = 0;
  int errors = 0;

  logic [63:0] pt_arr [3];
  bit          er_arr [3];

  sv39_walker dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vaddr_i(vaddr_i),
    .root_base_i(root_base_i), .acc_i(acc_i), .perm_ok_i(perm_ok_i),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i), .mem_rerr_i(mem_rerr_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .access_o(access_o),
    .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o), .fault_o(fault_o),
    .paddr_o(paddr_o), .pte_o(pte_o), .pte_addr_o(pte_addr_o),
    .level_o(level_o), .global_o(global_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit good, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [43:0] rnd_ppn();
    return {$urandom, $urandom};
  endfunction

  // kind: 0 valid clear, 1 write without read, 2 pointer, 3 leaf
  function automatic logic [63:0] mk_pte(input int kind, input int lvl, input bit mis, input bit g);
    logic [63:0] p;
    logic [43:0] ppn;
    p   = '0;
    ppn = rnd_ppn();
    case (kind)
      0: begin p[9:1] = 9'($urandom); p[0] = 1'b0; end
      1: begin p[0] = 1'b1; p[2] = 1'b1; p[1] = 1'b0; p[3] = 1'($urandom); end
      2: begin p[0] = 1'b1; end
      default: begin
        p[0] = 1'b1; p[1] = 1'b1; p[2] = 1'($urandom); p[3] = 1'($urandom);
        if (lvl > 0) begin
          if (mis) ppn[0] = 1'b1;
          else     ppn = ppn & ~((44'd1 << (9 * lvl)) - 44'd1);
        end
      end
    endcase
    p[5]     = g;
    p[53:10] = ppn;
    return p;
  endfunction

  task automatic run_walk(input logic [38:0] va, input logic [55:0] root, input bit perm,
                          input bit poke);
    int          lvl;
    logic [55:0] base;
    bit          g;
    bit          term;
    bit          eok;
    logic [2:0]  ef;
    string       freq;
    logic [55:0] eaddr;
    logic [55:0] lastaddr;
    logic [63:0] p;
    logic [55:0] epa;
    lvl = 2; base = root; g = 1'b0; term = 1'b0; eok = 1'b0; ef = 3'd0;
    freq = "R8"; epa = '0; lastaddr = '0; p = '0;
    @(negedge clk);
    start_i = 1'b1; vaddr_i = va; root_base_i = root; acc_i = 2'($urandom);
    @(negedge clk);
    start_i = 1'b0; vaddr_i = ~va; root_base_i = ~root;
    while (!term) begin
      int t;
      t = 0;
      while (!mem_req_o && t < 50) begin
        @(negedge clk);
        t++;
      end
      if (!mem_req_o) begin
        chk(1'b0, "R3", 64'(mem_req_o), 64'd1);
        return;
      end
      eaddr = base + 56'({va[12 + 9*lvl +: 9], 3'b000});
      chk(mem_addr_o == eaddr, (lvl == 2) ? "R2" : "R5", 64'(mem_addr_o), 64'(eaddr));
      @(negedge clk);
      chk(!mem_req_o && busy_o, "R3", 64'(mem_req_o), 64'd0);
      if (poke && lvl == 2) begin
        start_i = 1'b1; vaddr_i = ~va;
        @(negedge clk);
        start_i = 1'b0;
        chk(!mem_req_o, "R12", 64'(mem_req_o), 64'd0);
      end
      repeat ($urandom % 3) @(negedge clk);
      p = pt_arr[lvl];
      mem_rvalid_i = 1'b1; mem_rdata_i = p; mem_rerr_i = er_arr[lvl]; perm_ok_i = perm;
      @(negedge clk);
      mem_rvalid_i = 1'b0; mem_rerr_i = 1'b0; mem_rdata_i = $urandom;
      lastaddr = eaddr;
      if (er_arr[lvl]) begin
        ef = 3'd4; freq = "R10"; term = 1'b1;
      end else begin
        g = g | p[5];
        if (!p[0] || (p[2] && !p[1])) begin
          ef = 3'd1; freq = "R4"; term = 1'b1;
        end else if (!p[1] && !p[3]) begin
          if (lvl == 0) begin
            ef = 3'd1; freq = "R5"; term = 1'b1;
          end else begin
            chk(busy_o && !done_o, "R12", 64'(busy_o), 64'd1);
            base = {p[53:10], 12'h000};
            lvl--;
          end
        end else if (!perm) begin
          ef = 3'd2; freq = "R6"; term = 1'b1;
        end else begin
          logic [43:0] mask;
          mask = (44'd1 << (9 * lvl)) - 44'd1;
          if ((p[53:10] & mask) != 44'd0) begin
            ef = 3'd3; freq = "R7"; term = 1'b1;
          end else begin
            ef = 3'd0; eok = 1'b1; term = 1'b1;
            epa = {p[53:10] | ({17'd0, va[38:12]} & mask), va[11:0]};
          end
        end
      end
    end
    chk(done_o && !busy_o, "R13", {62'd0, done_o, busy_o}, 64'd2);
    chk(fault_o == ef, freq, 64'(fault_o), 64'(ef));
    chk(ok_o == eok, "R8", 64'(ok_o), 64'(eok));
    if (ef != 3'd4) begin
      chk(level_o == 2'(lvl), "R11", 64'(level_o), 64'(lvl));
      chk(pte_o == p, "R11", pte_o, p);
      chk(pte_addr_o == lastaddr, "R11", 64'(pte_addr_o), 64'(lastaddr));
      chk(global_o == g, "R9", 64'(global_o), 64'(g));
    end
    if (eok) chk(paddr_o == epa, "R8", 64'(paddr_o), 64'(epa));
    @(negedge clk);
    chk(!done_o && !busy_o && !mem_req_o, "R13", {61'd0, done_o, busy_o, mem_req_o}, 64'd0);
    chk(fault_o == ef, "R13", 64'(fault_o), 64'(ef));
  endtask

  function automatic logic [55:0] rnd_root();
    return {rnd_ppn(), 12'h000};
  endfunction

  function automatic logic [38:0] rnd_va();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0; start_i = 1'b0; vaddr_i = '0; root_base_i = '0; acc_i = '0;
    perm_ok_i = 1'b0; mem_rvalid_i = 1'b0; mem_rdata_i = '0; mem_rerr_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !mem_req_o, "R1", {61'd0, busy_o, done_o, mem_req_o}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy_o && !done_o && !mem_req_o, "R1", {61'd0, busy_o, done_o, mem_req_o}, 64'd0);

    // R8 four-kilobyte page through two pointers
    pt_arr[2] = mk_pte(2, 2, 0, 0); pt_arr[1] = mk_pte(2, 1, 0, 0); pt_arr[0] = mk_pte(3, 0, 0, 0);
    er_arr = '{0, 0, 0};
    run_walk(rnd_va(), rnd_root(), 1'b1, 1'b0);
    // R8 level-1 superpage
    pt_arr[2] = mk_pte(2, 2, 0, 0); pt_arr[1] = mk_pte(3, 1, 0, 0);
    run_walk(rnd_va(), rnd_root(), 1'b1, 1'b0);
    // R8 level-2 superpage
    pt_arr[2] = mk_pte(3, 2, 0, 0);
    run_walk(rnd_va(), rnd_root(), 1'b1, 1'b0);
    // R7 misaligned at levels 2 and 1
    pt_arr[2] = mk_pte(3, 2, 1, 0);
    run_walk(rnd_va(), rnd_root(), 1'b1, 1'b0);
    pt_arr[2] = mk_pte(2, 2, 0, 0); pt_arr[1] = mk_pte(3, 1, 1, 0);
    run_walk(rnd_va(), rnd_root(), 1'b1, 1'b0);
    // R5 pointer at level 0
    pt_arr[2] = mk_pte(2, 2, 0, 0); pt_arr[1] = mk_pte(2, 1, 0, 0); pt_arr[0] = mk_pte(2, 0, 0, 0);
    run_walk(rnd_va(), rnd_root(), 1'b1, 1'b0);
    // R10 access error at level 1
    er_arr = '{0, 1, 0};
    run_walk(rnd_va(), rnd_root(), 1'b1, 1'b0);
    er_arr = '{0, 0, 0};
    // R6 permission refused
    pt_arr[2] = mk_pte(3, 2, 0, 1);
    run_walk(rnd_va(), rnd_root(), 1'b0, 1'b0);
    // R9 global set only at root, success at level 0
    pt_arr[2] = mk_pte(2, 2, 0, 1); pt_arr[1] = mk_pte(2, 1, 0, 0); pt_arr[0] = mk_pte(3, 0, 0, 0);
    run_walk(rnd_va(), rnd_root(), 1'b1, 1'b0);
    // R4 write-without-read and valid-clear
    pt_arr[2] = mk_pte(2, 2, 0, 0); pt_arr[1] = mk_pte(1, 1, 0, 0);
    run_walk(rnd_va(), rnd_root(), 1'b1, 1'b0);
    pt_arr[2] = mk_pte(0, 2, 0, 0);
    run_walk(rnd_va(), rnd_root(), 1'b1, 1'b0);
    // R12 start while busy is dropped
    pt_arr[2] = mk_pte(2, 2, 0, 0); pt_arr[1] = mk_pte(3, 1, 0, 0);
    run_walk(rnd_va(), rnd_root(), 1'b1, 1'b1);

    for (int n = 0; n < 150; n++) begin
      for (int l = 0; l < 3; l++) begin
        int r;
        int kind;
        r = $urandom % 10;
        kind = (r == 0) ? 0 : (r == 1) ? 1 : (r < 6) ? 2 : 3;
        pt_arr[l] = mk_pte(kind, l, ($urandom % 3) == 0, 1'($urandom));
        er_arr[l] = (($urandom % 12) == 0);
      end
      run_walk(rnd_va(), rnd_root(), ($urandom % 7) != 0, ($urandom % 5) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule